// File: doc/BRIEF.md
# Bus Target Data-Phase Controller

This block is the bus-facing half of a simple 32-bit parallel-bus target. It watches every address phase and compares the upper address bits with a programmable base. It claims a register read or register write command that falls inside its window by asserting device-select. It then runs one data phase with the initiator-ready / target-ready handshake and holds wait states until both sides are ready. On the far side it drives a single-cycle register port: a read strobe one cycle before data is offered, and a write strobe in the cycle the data phase completes.

The block never bursts. Every claimed cycle presents stop together with target-ready, so the initiator is disconnected after the first transfer. If the initiator still holds frame when that transfer completes, the block keeps stop and device-select up until frame is released. The block drives even parity one clock behind the data it outputs. It checks the parity of write data against the parity bit that arrives one clock later. It reports a mismatch on a parity-error output only when reporting is enabled.

All bus signals are modelled here as active-high, separate input and output pins with an output-enable for the data bus. Bus reset is synchronous and active low.

Top module: `bus_target_ctl`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released with frame low, device-select, target-ready, stop, data output-enable, parity output-enable, parity-error and both register strobes are all low.
- R2: An address phase is a cycle in idle where frame is sampled high. It is claimed when address bits 31:6 equal base bits 31:6 and the command on the byte-enable lines is 4'b0110 (register read) or 4'b0111 (register write). Device-select rises in the next cycle, and target-ready stays low in that cycle (one fixed wait state).
- R3: An address phase that misses the window, or that carries any other command, leaves device-select, target-ready, stop and both strobes low until the bus is idle (frame and initiator-ready both sampled low).
- R4: From the second cycle after a claimed address phase, target-ready and stop are high. The data phase completes on the first rising edge where initiator-ready is also high. Until then target-ready is held.
- R5: For a read, the read strobe is high for exactly the cycle after the address phase, with register index equal to address bits 5:2. Data output-enable is high while target-ready is high, and the data output carries the register value.
- R6: For a write, the write strobe is high only in the cycle in which the data phase completes. It carries the bus data, the byte-enable lanes (1 = lane written) and address bits 5:2 as index. Each claimed write produces exactly one strobe.
- R7: If frame is still high when the data phase completes, target-ready drops in the next cycle while stop and device-select stay high. These are released in the cycle after frame is sampled low, and no further strobe occurs.
- R8: If frame is low when the data phase completes, device-select, target-ready and stop are all low in the next cycle.
- R9: In every cycle, the parity output equals the XOR of the data output and byte-enable inputs of the previous cycle. The parity output-enable equals the data output-enable of the previous cycle.
- R10: For a write completing at edge k, the parity bit sampled at edge k+1 is compared with the XOR of the data and byte-enables sampled at edge k. If they differ and reporting is enabled at edge k+1, parity-error is high for exactly the one cycle following edge k+2.
- R11: Parity-error stays low when reporting is disabled, when parity matches, and for read transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low bus reset |
| base_i | input | 32 | Window base; bits 31:6 are compared |
| perr_en_i | input | 1 | Enables parity-error reporting |
| frame_i | input | 1 | Transaction in progress, from initiator |
| irdy_i | input | 1 | Initiator ready |
| ad_i | input | 32 | Address/data from initiator |
| cbe_i | input | 4 | Command in address phase, byte-enable lanes in data phase |
| par_i | input | 1 | Even parity from initiator, one clock late |
| ad_o | output | 32 | Read data toward the bus |
| ad_oe_o | output | 1 | Data output-enable |
| par_o | output | 1 | Even parity of the previous cycle |
| par_oe_o | output | 1 | Parity output-enable |
| devsel_o | output | 1 | Cycle claimed |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Disconnect request |
| perr_o | output | 1 | Parity-error report |
| reg_idx_o | output | 4 | Register index |
| reg_rd_o | output | 1 | Register read strobe |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 32 | Register write data |
| reg_be_o | output | 4 | Register write lane enables |
| reg_rdata_i | input | 32 | Register read data, same cycle as strobe |

## Verification
The bench varies how many wait states the initiator adds. A design that completes on target-ready alone would strobe a write early or offer stale read data. It holds frame through the transfer to force the disconnect path; a target that accepted a second phase would produce a second write strobe or drop stop too soon. It sends window misses and foreign commands at a matching address, which a loose decoder would claim. It corrupts the late parity bit with reporting on and off, and on reads. A checker that compared against the wrong cycle, ignored the enable or pulsed at the wrong delay would show up as a missing, extra or misplaced parity-error cycle.

// File: rtl/bt_pkg.sv
// Shared types for the bus target: controller states and the two
// command codes the target answers to.
package bt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for an address phase
        ST_CLAIM,  // device-select up, fixed wait state, read fetch
        ST_XFER,   // target-ready and stop up, waiting for initiator
        ST_DISC,   // transfer done, frame still high: hold stop
        ST_SKIP    // cycle belongs to someone else: wait for idle bus
    } bt_state_e;

    localparam logic [3:0] CMD_REG_RD = 4'b0110;
    localparam logic [3:0] CMD_REG_WR = 4'b0111;
endpackage

// File: rtl/bt_decode.sv
// Address-phase decoder. Compares the upper address bits with the base
// and recognises the two supported commands. Purely combinational;
// assumes the caller only uses the result in an address-phase cycle.
module bt_decode #(
    parameter int DW       = 32,
    parameter int BEW      = DW / 8,
    parameter int WIN_BITS = 6
) (
    input  logic [DW-1:0]  ad,
    input  logic [BEW-1:0] cbe,
    input  logic [DW-1:0]  base,
    output logic           hit,
    output logic           is_wr
);
    import bt_pkg::*;

    logic win_match;
    logic cmd_ok;

    // Window match on the bits above the window size, command filter.
    always_comb begin
        win_match = (ad[DW-1:WIN_BITS] == base[DW-1:WIN_BITS]);
        cmd_ok    = (cbe == CMD_REG_RD) || (cbe == CMD_REG_WR);
        hit       = win_match && cmd_ok;
        is_wr     = (cbe == CMD_REG_WR);
    end
endmodule

// File: rtl/bt_parity.sv
// Even-parity generator and checker. The driven parity lags the data it
// covers by one clock. The received parity also lags by one clock, so the
// checker compares against parity captured in the previous cycle and
// registers the result once more before reporting.
module bt_parity #(
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  ad_out,
    input  logic           ad_oe,
    input  logic [DW-1:0]  ad_in,
    input  logic [BEW-1:0] cbe,
    input  logic           par_in,
    input  logic           chk_stb,
    input  logic           perr_en,
    output logic           par_out,
    output logic           par_oe,
    output logic           perr
);
    logic calc_q;
    logic pend_q;
    logic err_q;

    // Outgoing parity and its enable, one clock behind the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= ^{ad_out, cbe};
            par_oe  <= ad_oe;
        end
    end

    // Capture parity of a received write phase, compare next clock, report after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            calc_q <= 1'b0;
            pend_q <= 1'b0;
            err_q  <= 1'b0;
            perr   <= 1'b0;
        end else begin
            calc_q <= ^{ad_in, cbe};
            pend_q <= chk_stb;
            err_q  <= pend_q && perr_en && (calc_q != par_in);
            perr   <= err_q;
        end
    end
endmodule

// File: rtl/bt_fsm.sv
// Transaction controller. Claims a decoded cycle, inserts one fixed wait
// state, then offers one data phase with stop asserted (disconnect after
// the first transfer). Assumes the decoder result is only meaningful while
// idle with frame high.
module bt_fsm #(
    parameter int DW       = 32,
    parameter int WIN_BITS = 6,
    parameter int IDX_W    = WIN_BITS - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame,
    input  logic             irdy,
    input  logic             addr_hit,
    input  logic             addr_wr,
    input  logic [DW-1:0]    ad_in,
    output logic             devsel,
    output logic             trdy,
    output logic             stop,
    output logic             ad_oe,
    output logic             rd_stb,
    output logic             wr_stb,
    output logic [IDX_W-1:0] idx
);
    import bt_pkg::*;

    bt_state_e state_q, state_d;
    logic      wr_q;

    // Next-state selection from the bus handshake.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame) state_d = addr_hit ? ST_CLAIM : ST_SKIP;
            ST_CLAIM: state_d = ST_XFER;
            ST_XFER:  if (irdy) state_d = frame ? ST_DISC : ST_IDLE;
            ST_DISC:  if (!frame) state_d = ST_IDLE;
            ST_SKIP:  if (!frame && !irdy) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register plus command and index capture at the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            idx     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && frame) begin
                wr_q <= addr_wr;
                idx  <= ad_in[WIN_BITS-1:2];
            end
        end
    end

    // Bus-side and register-side outputs decoded from the state.
    always_comb begin
        devsel = (state_q == ST_CLAIM) || (state_q == ST_XFER) || (state_q == ST_DISC);
        trdy   = (state_q == ST_XFER);
        stop   = (state_q == ST_XFER) || (state_q == ST_DISC);
        ad_oe  = (state_q == ST_XFER) && !wr_q;
        rd_stb = (state_q == ST_CLAIM) && !wr_q;
        wr_stb = (state_q == ST_XFER) && irdy && wr_q;
    end
endmodule

// File: rtl/bus_target_ctl.sv
// Top of the bus target. Ties decoder, controller and parity unit
// together and holds the read data fetched during the wait state.
// Assumes a single-cycle register port (read data valid with the strobe).
module bus_target_ctl #(
    parameter int DW       = 32,
    parameter int BEW      = DW / 8,
    parameter int WIN_BITS = 6,
    parameter int IDX_W    = WIN_BITS - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    base_i,
    input  logic             perr_en_i,
    input  logic             frame_i,
    input  logic             irdy_i,
    input  logic [DW-1:0]    ad_i,
    input  logic [BEW-1:0]   cbe_i,
    input  logic             par_i,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe_o,
    output logic             par_o,
    output logic             par_oe_o,
    output logic             devsel_o,
    output logic             trdy_o,
    output logic             stop_o,
    output logic             perr_o,
    output logic [IDX_W-1:0] reg_idx_o,
    output logic             reg_rd_o,
    output logic             reg_wr_o,
    output logic [DW-1:0]    reg_wdata_o,
    output logic [BEW-1:0]   reg_be_o,
    input  logic [DW-1:0]    reg_rdata_i
);
    logic hit;
    logic is_wr;

    bt_decode #(.DW(DW), .BEW(BEW), .WIN_BITS(WIN_BITS)) u_dec (
        .ad    (ad_i),
        .cbe   (cbe_i),
        .base  (base_i),
        .hit   (hit),
        .is_wr (is_wr)
    );

    bt_fsm #(.DW(DW), .WIN_BITS(WIN_BITS), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame    (frame_i),
        .irdy     (irdy_i),
        .addr_hit (hit),
        .addr_wr  (is_wr),
        .ad_in    (ad_i),
        .devsel   (devsel_o),
        .trdy     (trdy_o),
        .stop     (stop_o),
        .ad_oe    (ad_oe_o),
        .rd_stb   (reg_rd_o),
        .wr_stb   (reg_wr_o),
        .idx      (reg_idx_o)
    );

    // Hold the register value fetched with the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) ad_o <= '0;
        else if (reg_rd_o) ad_o <= reg_rdata_i;
    end

    assign reg_wdata_o = ad_i;
    assign reg_be_o    = cbe_i;

    bt_parity #(.DW(DW), .BEW(BEW)) u_par (
        .clk     (clk),
        .rst_n   (rst_n),
        .ad_out  (ad_o),
        .ad_oe   (ad_oe_o),
        .ad_in   (ad_i),
        .cbe     (cbe_i),
        .par_in  (par_i),
        .chk_stb (reg_wr_o),
        .perr_en (perr_en_i),
        .par_out (par_o),
        .par_oe  (par_oe_o),
        .perr    (perr_o)
    );
endmodule

// File: rtl/bus_target_ctl_chk.sv
// Property checker for bus_target_ctl, attached by bind. Observes ports
// only and relates the handshake signals across cycles.
module bus_target_ctl_chk #(
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_i,
    input logic           irdy_i,
    input logic           perr_en_i,
    input logic [DW-1:0]  ad_o,
    input logic           ad_oe_o,
    input logic [BEW-1:0] cbe_i,
    input logic           par_o,
    input logic           par_oe_o,
    input logic           devsel_o,
    input logic           trdy_o,
    input logic           stop_o,
    input logic           perr_o,
    input logic           reg_wr_o
);
    p_claim_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_o) |-> !trdy_o);

    p_trdy_claimed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trdy_o |-> devsel_o && stop_o);

    p_wr_on_handshake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |-> trdy_o && irdy_i);

    p_disconnect_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_o && irdy_i && frame_i) |=> (!trdy_o && stop_o && devsel_o));

    p_release_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy_o && irdy_i && !frame_i) |=> (!devsel_o && !trdy_o && !stop_o));

    p_par_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (par_o == ^{$past(ad_o), $past(cbe_i)}) && (par_oe_o == $past(ad_oe_o)));

    p_perr_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |-> $past(perr_en_i, 2));

    p_perr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> !perr_o);
endmodule

bind bus_target_ctl bus_target_ctl_chk #(.DW(DW), .BEW(BEW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_i   (frame_i),
    .irdy_i    (irdy_i),
    .perr_en_i (perr_en_i),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .cbe_i     (cbe_i),
    .par_o     (par_o),
    .par_oe_o  (par_oe_o),
    .devsel_o  (devsel_o),
    .trdy_o    (trdy_o),
    .stop_o    (stop_o),
    .perr_o    (perr_o),
    .reg_wr_o  (reg_wr_o)
);

// File: tb/bus_target_ctl_tb.sv
`timescale 1ns/1ps
module bus_target_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] base_i = 32'h4000_0000;
    logic        perr_en_i = 1'b1;
    logic        frame_i = 1'b0;
    logic        irdy_i = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0;
    logic [31:0] ad_o;
    logic        ad_oe_o, par_o, par_oe_o, devsel_o, trdy_o, stop_o, perr_o;
    logic [3:0]  reg_idx_o;
    logic        reg_rd_o, reg_wr_o;
    logic [31:0] reg_wdata_o;
    logic [3:0]  reg_be_o;
    logic [31:0] reg_rdata_i;

    always #5 clk = ~clk;

    bus_target_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .base_i(base_i), .perr_en_i(perr_en_i),
        .frame_i(frame_i), .irdy_i(irdy_i), .ad_i(ad_i), .cbe_i(cbe_i),
        .par_i(par_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .par_o(par_o),
        .par_oe_o(par_oe_o), .devsel_o(devsel_o), .trdy_o(trdy_o),
        .stop_o(stop_o), .perr_o(perr_o), .reg_idx_o(reg_idx_o),
        .reg_rd_o(reg_rd_o), .reg_wr_o(reg_wr_o), .reg_wdata_o(reg_wdata_o),
        .reg_be_o(reg_be_o), .reg_rdata_i(reg_rdata_i)
    );

    // Back-end register bank driven by the strobes, and an independent reference copy.
    logic [31:0] bank [16];
    logic [31:0] ref_bank [16];
    assign reg_rdata_i = bank[reg_idx_o];
    always @(posedge clk) begin
        if (reg_wr_o)
            for (int b = 0; b < 4; b++)
                if (reg_be_o[b]) bank[reg_idx_o][8*b +: 8] <= reg_wdata_o[8*b +: 8];
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Expected values for the current cycle, set by the stimulus tasks.
    bit          e_dev, e_trdy, e_stop, e_oe, e_rd, e_wr;
    logic [3:0]  e_idx;
    logic [31:0] e_wdata, e_rdata;
    logic [3:0]  e_be;
    int          perr_at = -1;
    int          flip_at = -1;
    logic        prev_par = 1'b0;
    logic        prev_out_par = 1'b0;
    bit          prev_e_oe = 0;
    bit          par_valid = 0;
    string       tag = "R1";

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, settle, compare every output.
    task automatic step(input bit fr, input bit ir, input logic [31:0] ad, input logic [3:0] be);
        @(negedge clk);
        frame_i = fr; irdy_i = ir; ad_i = ad; cbe_i = be;
        par_i = prev_par ^ (cyc == flip_at);
        prev_par = ^{ad, be};
        #1;
        chk(devsel_o == e_dev, tag, "devsel (R2)", 32'(devsel_o), 32'(e_dev));
        chk(trdy_o == e_trdy, tag, "trdy (R4)", 32'(trdy_o), 32'(e_trdy));
        chk(stop_o == e_stop, tag, "stop (R7)", 32'(stop_o), 32'(e_stop));
        chk(ad_oe_o == e_oe, tag, "ad_oe (R5)", 32'(ad_oe_o), 32'(e_oe));
        chk(reg_rd_o == e_rd, tag, "rd strobe (R5)", 32'(reg_rd_o), 32'(e_rd));
        chk(reg_wr_o == e_wr, tag, "wr strobe (R6)", 32'(reg_wr_o), 32'(e_wr));
        if (e_rd) chk(reg_idx_o == e_idx, tag, "rd index (R5)", 32'(reg_idx_o), 32'(e_idx));
        if (e_oe) chk(ad_o == e_rdata, tag, "read data (R5)", ad_o, e_rdata);
        if (e_wr) begin
            chk(reg_idx_o == e_idx, tag, "wr index (R6)", 32'(reg_idx_o), 32'(e_idx));
            chk(reg_wdata_o == e_wdata, tag, "wr data (R6)", reg_wdata_o, e_wdata);
            chk(reg_be_o == e_be, tag, "wr lanes (R6)", 32'(reg_be_o), 32'(e_be));
        end
        chk(perr_o == (cyc == perr_at), tag, "perr (R10)", 32'(perr_o), 32'(cyc == perr_at));
        if (par_valid) begin
            chk(par_o == prev_out_par, tag, "par_o (R9)", 32'(par_o), 32'(prev_out_par));
            chk(par_oe_o == prev_e_oe, tag, "par_oe (R9)", 32'(par_oe_o), 32'(prev_e_oe));
        end
        prev_out_par = ^{ad_o, cbe_i};
        prev_e_oe = e_oe;
        par_valid = 1;
        cyc++;
    endtask

    task automatic exp_quiet();
        e_dev = 0; e_trdy = 0; e_stop = 0; e_oe = 0; e_rd = 0; e_wr = 0;
    endtask

    // One complete transaction from the initiator side, with expectations.
    task automatic txn(input string req, input logic [31:0] addr, input logic [3:0] cmd,
                       input logic [31:0] data, input logic [3:0] be, input int w,
                       input bit burst, input bit flip, input bit en, input bit hit);
        int start = cyc;
        bit is_rd = (cmd == 4'b0110);
        bit is_wr = (cmd == 4'b0111);
        int c = hit ? ((1 + w) > 2 ? (1 + w) : 2) : (1 + w);
        tag = req;
        perr_en_i = en;
        e_idx = addr[5:2];
        e_wdata = data;
        e_be = be;
        e_rdata = ref_bank[addr[5:2]];
        flip_at = flip ? start + c + 1 : -1;
        perr_at = (hit && is_wr && flip && en) ? start + c + 3 : -1;
        exp_quiet();
        step(1'b1, 1'b0, addr, cmd);
        for (int t = 1; t <= c; t++) begin
            bit ir = (t >= 1 + w);
            bit fr = burst ? 1'b1 : !ir;
            e_dev = hit; e_trdy = hit && t >= 2; e_stop = e_trdy;
            e_rd = hit && is_rd && t == 1;
            e_wr = hit && is_wr && t == c;
            e_oe = hit && is_rd && t >= 2;
            step(fr, ir, is_wr ? data : 32'h0, be);
        end
        if (hit && burst) begin
            exp_quiet(); e_dev = 1; e_stop = 1;
            step(1'b1, 1'b1, 32'h0, be);
            step(1'b0, 1'b1, 32'h0, be);
        end
        exp_quiet();
        for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 32'h0, 4'h0);
        if (hit && is_wr)
            for (int b = 0; b < 4; b++)
                if (be[b]) ref_bank[addr[5:2]][8*b +: 8] = data[8*b +: 8];
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            bank[i] = 32'hA500_0000 + 32'(i) * 32'h0001_0203;
            ref_bank[i] = bank[i];
        end
        exp_quiet();
        e_idx = '0; e_wdata = '0; e_be = '0; e_rdata = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(!devsel_o && !trdy_o && !stop_o && !ad_oe_o && !par_oe_o && !perr_o
            && !reg_rd_o && !reg_wr_o, "R1", "outputs in reset", 32'(devsel_o), 32'h0);
        rst_n = 1'b1;
        tag = "R1";
        step(1'b0, 1'b0, 32'h0, 4'h0);
        step(1'b0, 1'b0, 32'h0, 4'h0);

        txn("R6", 32'h4000_0014, 4'b0111, 32'h1234_5678, 4'hF, 0, 0, 0, 1, 1);
        txn("R5", 32'h4000_0014, 4'b0110, 32'h0, 4'hF, 0, 0, 0, 1, 1);
        txn("R4", 32'h4000_0008, 4'b0110, 32'h0, 4'hF, 4, 0, 0, 1, 1);
        txn("R8", 32'h4000_003C, 4'b0111, 32'hCAFE_0001, 4'hF, 3, 0, 0, 1, 1);
        txn("R7", 32'h4000_0020, 4'b0111, 32'h0BAD_F00D, 4'hF, 1, 1, 0, 1, 1);
        txn("R7", 32'h4000_0020, 4'b0110, 32'h0, 4'hF, 2, 1, 0, 1, 1);
        txn("R3", 32'h4000_0104, 4'b0111, 32'hDEAD_BEEF, 4'hF, 2, 0, 0, 1, 0);
        txn("R3", 32'h4000_0004, 4'b0010, 32'h0, 4'hF, 1, 0, 0, 1, 0);
        txn("R6", 32'h4000_0010, 4'b0111, 32'h7788_99AA, 4'b0101, 1, 0, 0, 1, 1);
        txn("R6", 32'h4000_0010, 4'b0110, 32'h0, 4'hF, 0, 0, 0, 1, 1);
        txn("R10", 32'h4000_0030, 4'b0111, 32'h0F0F_0F0F, 4'hF, 0, 0, 1, 1, 1);
        txn("R10", 32'h4000_0034, 4'b0111, 32'h1111_2222, 4'hC, 3, 1, 1, 1, 1);
        txn("R11", 32'h4000_0030, 4'b0111, 32'h5555_AAAA, 4'hF, 1, 0, 1, 0, 1);
        txn("R11", 32'h4000_0030, 4'b0110, 32'h0, 4'hF, 1, 0, 1, 1, 1);
        base_i = 32'h8000_1040;
        txn("R2", 32'h8000_1048, 4'b0111, 32'h0102_0304, 4'hF, 0, 0, 0, 1, 1);
        txn("R2", 32'h8000_1048, 4'b0110, 32'h0, 4'hF, 2, 0, 0, 1, 1);
        txn("R3", 32'h4000_0008, 4'b0110, 32'h0, 4'hF, 0, 0, 0, 1, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule